// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Aligner

This unit takes one instruction fetch request at a time and returns a 32-bit instruction word. The request carries a byte address and a flag that enables compressed (16-bit) instructions.

When compressed mode is on and the address falls in the middle of a 32-bit word (low two bits equal 2), the unit fetches the instruction as two halfwords. It first reads the halfword at the request address. If that halfword is a compressed instruction, the fetch ends there. If it is not, the unit reads the next halfword and places it in the upper half of the result. In every other case the unit makes one aligned 32-bit read.

Every read goes out on the memory port as its own request. The memory side translates and checks each request separately, so the two halves of one instruction may come from different pages, and either half may fault. The result is either an instruction with a compressed flag or a fetch fault that carries the address of the halfword or word that failed.

Top module: `fetch_aligner`

## Requirements
- R1: An aligned request, or any request made with compressed mode off, issues exactly one 32-bit read (`memReqWide`=1) at the request address with bits [1:0] cleared. The whole response word is returned as the instruction.
- R2: With compressed mode on and request address bits [1:0] = 2'b10, the first read is 16-bit (`memReqWide`=0) at the request address. Its response bits [15:0] become instruction bits [15:0]. A read request stays asserted, with a stable address, until `memRspValid`.
- R3: When that first halfword has bits [1:0] = 2'b11, a second 16-bit read is issued at request address + 2, even when it lies on another page. Its response bits [15:0] become instruction bits [31:16], and `insnCompressed` is 0.
- R4: When the first halfword on the split path has bits [1:0] other than 2'b11, no second read is issued. Instruction bits [31:16] are zero and `insnCompressed` is 1.
- R5: A fault on the first read (split or aligned) produces a one-cycle `faultValid` with `faultAddr` equal to the address of that read. No `insnValid` is produced and no further read is issued.
- R6: A fault on the second halfword read produces `faultValid` with `faultAddr` equal to request address + 2, and no `insnValid`.
- R7: The unit handles one fetch at a time. `reqReady` is 1 only when the unit is idle, and a request presented while it is busy is ignored. `insnValid` and `faultValid` are single-cycle pulses and are never both set.
- R8: On the aligned path, `insnCompressed` is 1 exactly when compressed mode is on and response bits [1:0] are not 2'b11.
- R9: After reset, `reqReady`=1 and `memReqValid`, `insnValid` and `faultValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Fetch request strobe, sampled while idle |
| reqAddr | input | AW | Fetch byte address |
| reqCompEn | input | 1 | Compressed instruction mode enable |
| reqReady | output | 1 | Unit idle and accepting a request |
| memReqValid | output | 1 | Memory read request, held until response |
| memReqAddr | output | AW | Virtual address of the read |
| memReqWide | output | 1 | 1: 32-bit read, 0: 16-bit read |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | ILEN | Read data; a 16-bit read returns data in bits [15:0] |
| memRspFault | input | 1 | Translation or access fault on this read |
| insnValid | output | 1 | Instruction result pulse |
| insnData | output | ILEN | Assembled instruction |
| insnCompressed | output | 1 | Result is a compressed instruction |
| faultValid | output | 1 | Fetch fault pulse |
| faultAddr | output | AW | Address of the read that faulted |

## Verification
The hardest case to reach is a fault on the second halfword. It needs a split address whose first halfword is not compressed, sits on a good page, and is followed by a halfword on a faulting page. The bench's memory model returns halfwords whose low bits depend on address bit 3, and it marks one whole page as faulting. A request at the last halfword before that page therefore produces a full-length first half and then a faulting second half. Requests that arrive while the unit is busy are produced by holding `reqValid` high with another address for the whole fetch, and the bench checks the count of reads and the result.

// File: rtl/fa_pkg.sv
package fa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } faState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch a new request
    logic selHigh;   // address the second halfword
    logic takeWide;  // store a full aligned word
    logic takeLow;   // store first halfword
    logic takeHigh;  // store second halfword
    logic setFault;  // record fault on the current read
    logic present;   // result is on the outputs this cycle
  } faStrobe_t;

  function automatic logic isCompressedHalf(input logic [1:0] lowBits);
    return lowBits != 2'b11;
  endfunction

endpackage

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import fa_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      splitMode,
  input  logic      lowIsCompressed,
  input  logic      memRspValid,
  input  logic      memRspFault,
  output logic      reqReady,
  output logic      memReqValid,
  output faStrobe_t strobe
);

  faState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_LOW;
        end
      end
      ST_LOW: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          if (memRspFault) begin
            strobe.setFault = 1'b1;
            stateNext       = ST_DONE;
          end else if (!splitMode) begin
            strobe.takeWide = 1'b1;
            stateNext       = ST_DONE;
          end else begin
            strobe.takeLow = 1'b1;
            stateNext      = lowIsCompressed ? ST_DONE : ST_HIGH;
          end
        end
      end
      ST_HIGH: begin
        memReqValid    = 1'b1;
        strobe.selHigh = 1'b1;
        if (memRspValid) begin
          if (memRspFault) strobe.setFault = 1'b1;
          else             strobe.takeHigh = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        strobe.present = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/fa_datapath.sv
module fa_datapath
  import fa_pkg::*;
#(
  parameter int AW   = 32,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  faStrobe_t       strobe,
  input  logic [AW-1:0]   reqAddr,
  input  logic            reqCompEn,
  input  logic [ILEN-1:0] memRspData,
  output logic            splitMode,
  output logic            lowIsCompressed,
  output logic [AW-1:0]   memReqAddr,
  output logic            memReqWide,
  output logic            insnValid,
  output logic [ILEN-1:0] insnData,
  output logic            insnCompressed,
  output logic            faultValid,
  output logic [AW-1:0]   faultAddr
);

  localparam int HALF      = ILEN / 2;
  localparam int HALFBYTES = HALF / 8;
  localparam int WORDBITS  = $clog2(ILEN / 8);

  logic [AW-1:0]   baseAddr;
  logic            compEn;
  logic            splitReg;
  logic [ILEN-1:0] insnReg;
  logic            compReg;
  logic            faultReg;
  logic [AW-1:0]   faultAddrReg;
  logic [AW-1:0]   alignedAddr;
  logic [AW-1:0]   highAddr;

  assign alignedAddr = {baseAddr[AW-1:WORDBITS], {WORDBITS{1'b0}}};
  assign highAddr    = baseAddr + AW'(HALFBYTES);

  always_comb begin
    if (strobe.selHigh)  memReqAddr = highAddr;
    else if (splitReg)   memReqAddr = baseAddr;
    else                 memReqAddr = alignedAddr;
  end

  assign memReqWide      = !splitReg;
  assign splitMode       = splitReg;
  assign lowIsCompressed = isCompressedHalf(memRspData[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr     <= '0;
      compEn       <= 1'b0;
      splitReg     <= 1'b0;
      insnReg      <= '0;
      compReg      <= 1'b0;
      faultReg     <= 1'b0;
      faultAddrReg <= '0;
    end else begin
      if (strobe.capture) begin
        baseAddr     <= reqAddr;
        compEn       <= reqCompEn;
        splitReg     <= reqCompEn && (reqAddr[WORDBITS-1:0] == WORDBITS'(HALFBYTES));
        insnReg      <= '0;
        compReg      <= 1'b0;
        faultReg     <= 1'b0;
        faultAddrReg <= '0;
      end
      if (strobe.takeWide) begin
        insnReg <= memRspData;
        compReg <= compEn && isCompressedHalf(memRspData[1:0]);
      end
      if (strobe.takeLow) begin
        insnReg <= {{HALF{1'b0}}, memRspData[HALF-1:0]};
        compReg <= isCompressedHalf(memRspData[1:0]);
      end
      if (strobe.takeHigh) begin
        insnReg[ILEN-1:HALF] <= memRspData[HALF-1:0];
      end
      if (strobe.setFault) begin
        faultReg     <= 1'b1;
        faultAddrReg <= memReqAddr;
      end
    end
  end

  assign insnValid      = strobe.present && !faultReg;
  assign faultValid     = strobe.present && faultReg;
  assign insnData       = insnReg;
  assign insnCompressed = insnValid && compReg;
  assign faultAddr      = faultAddrReg;

endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int AW   = 32,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [AW-1:0]   reqAddr,
  input  logic            reqCompEn,
  output logic            reqReady,
  output logic            memReqValid,
  output logic [AW-1:0]   memReqAddr,
  output logic            memReqWide,
  input  logic            memRspValid,
  input  logic [ILEN-1:0] memRspData,
  input  logic            memRspFault,
  output logic            insnValid,
  output logic [ILEN-1:0] insnData,
  output logic            insnCompressed,
  output logic            faultValid,
  output logic [AW-1:0]   faultAddr
);

  faStrobe_t strobe;
  logic      splitMode;
  logic      lowIsCompressed;

  fa_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .reqValid        (reqValid),
    .splitMode       (splitMode),
    .lowIsCompressed (lowIsCompressed),
    .memRspValid     (memRspValid),
    .memRspFault     (memRspFault),
    .reqReady        (reqReady),
    .memReqValid     (memReqValid),
    .strobe          (strobe)
  );

  fa_datapath #(.AW(AW), .ILEN(ILEN)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .reqAddr         (reqAddr),
    .reqCompEn       (reqCompEn),
    .memRspData      (memRspData),
    .splitMode       (splitMode),
    .lowIsCompressed (lowIsCompressed),
    .memReqAddr      (memReqAddr),
    .memReqWide      (memReqWide),
    .insnValid       (insnValid),
    .insnData        (insnData),
    .insnCompressed  (insnCompressed),
    .faultValid      (faultValid),
    .faultAddr       (faultAddr)
  );

endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int AW   = 32,
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqReady,
  input logic            memReqValid,
  input logic [AW-1:0]   memReqAddr,
  input logic            memReqWide,
  input logic            memRspValid,
  input logic [ILEN-1:0] memRspData,
  input logic            memRspFault,
  input logic            insnValid,
  input logic [ILEN-1:0] insnData,
  input logic            insnCompressed,
  input logic            faultValid
);

  AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWide |-> memReqAddr[1:0] == 2'b00); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid && $stable(memReqAddr)); // R2

  AST_SECOND_HALF_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memRspValid && !memReqWide && memReqAddr[1] && !memRspFault
      && memRspData[1:0] == 2'b11
    |=> memReqValid && !memReqWide && memReqAddr == $past(memReqAddr) + AW'(2)); // R3

  AST_COMP_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    insnValid && insnCompressed |-> insnData[1:0] != 2'b11); // R4

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !memReqValid && !insnValid); // R5

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    insnValid || faultValid |=> !insnValid && !faultValid); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R7

endmodule

bind fetch_aligner fa_checker #(.AW(AW), .ILEN(ILEN)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .reqReady       (reqReady),
  .memReqValid    (memReqValid),
  .memReqAddr     (memReqAddr),
  .memReqWide     (memReqWide),
  .memRspValid    (memRspValid),
  .memRspData     (memRspData),
  .memRspFault    (memRspFault),
  .insnValid      (insnValid),
  .insnData       (insnData),
  .insnCompressed (insnCompressed),
  .faultValid     (faultValid)
);

// File: tb/fetch_aligner_tb.sv
module fetch_aligner_tb;

  localparam int AW   = 32;
  localparam int ILEN = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic            reqCompEn = 1'b0;
  logic            reqReady;
  logic            memReqValid;
  logic [AW-1:0]   memReqAddr;
  logic            memReqWide;
  logic            memRspValid = 1'b0;
  logic [ILEN-1:0] memRspData = '0;
  logic            memRspFault = 1'b0;
  logic            insnValid;
  logic [ILEN-1:0] insnData;
  logic            insnCompressed;
  logic            faultValid;
  logic [AW-1:0]   faultAddr;

  always #5 clk = ~clk;

  fetch_aligner #(.AW(AW), .ILEN(ILEN)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCompEn(reqCompEn), .reqReady(reqReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memReqWide(memReqWide), .memRspValid(memRspValid),
    .memRspData(memRspData), .memRspFault(memRspFault), .insnValid(insnValid),
    .insnData(insnData), .insnCompressed(insnCompressed), .faultValid(faultValid),
    .faultAddr(faultAddr)
  );

  int compared = 0;
  int mismatched = 0;
  bit summaryDone = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // memory model: halfword content from address, one faulting page
  function automatic logic [15:0] memHalf(input logic [AW-1:0] a);
    return {a[17:4] ^ 14'h15A3, a[3] ? 2'b11 : 2'b01};
  endfunction

  function automatic bit badPage(input logic [AW-1:0] a);
    return a[31:12] == 20'h00005;
  endfunction

  int lat = 0;
  int waitCnt = 0;
  int rdCount = 0;
  logic [AW-1:0] rdAddr0, rdAddr1;
  logic rdWide0;

  always @(negedge clk) begin
    if (memRspValid) begin
      memRspValid <= 1'b0;
      memRspFault <= 1'b0;
      waitCnt     <= 0;
    end else if (rstN && memReqValid) begin
      if (waitCnt >= lat) begin
        memRspValid <= 1'b1;
        memRspFault <= badPage(memReqAddr);
        memRspData  <= memReqWide ? {memHalf(memReqAddr + 2), memHalf(memReqAddr)}
                                  : {16'h0, memHalf(memReqAddr)};
        if (rdCount == 0) begin rdAddr0 <= memReqAddr; rdWide0 <= memReqWide; end
        if (rdCount == 1) rdAddr1 <= memReqAddr;
        rdCount <= rdCount + 1;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  typedef struct {
    bit            isFault;
    logic [31:0]   data;
    bit            comp;
    logic [AW-1:0] fAddr;
    int            nRd;
    logic [AW-1:0] firstAddr;
    bit            firstWide;
    string         tag;
  } exp_t;

  function automatic exp_t refModel(input logic [AW-1:0] a, input bit en);
    exp_t e;
    logic [15:0] lo;
    logic [AW-1:0] a0;
    e.isFault = 0; e.data = '0; e.comp = 0; e.fAddr = '0;
    if (!(en && a[1:0] == 2'b10)) begin
      a0 = {a[AW-1:2], 2'b00};
      e.firstAddr = a0; e.firstWide = 1; e.nRd = 1; e.tag = "R1";
      if (badPage(a0)) begin e.isFault = 1; e.fAddr = a0; e.tag = "R5"; end
      else begin
        e.data = {memHalf(a0 + 2), memHalf(a0)};
        e.comp = en && (e.data[1:0] != 2'b11);
        e.tag = "R8";
      end
    end else begin
      e.firstAddr = a; e.firstWide = 0; e.nRd = 1; e.tag = "R2";
      if (badPage(a)) begin e.isFault = 1; e.fAddr = a; e.tag = "R5"; end
      else begin
        lo = memHalf(a);
        if (lo[1:0] != 2'b11) begin e.data = {16'h0, lo}; e.comp = 1; e.tag = "R4"; end
        else begin
          e.nRd = 2;
          if (badPage(a + 2)) begin e.isFault = 1; e.fAddr = a + 2; e.tag = "R6"; end
          else begin e.data = {memHalf(a + 2), lo}; e.tag = "R3"; end
        end
      end
    end
    return e;
  endfunction

  typedef struct packed {
    logic [31:0] addr;
    logic        en;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 1'b1, 4'd0},  // R1 aligned
    '{32'h0000_1002, 1'b1, 4'd1},  // R4 compressed at split address
    '{32'h0000_100A, 1'b1, 4'd2},  // R3 two halves
    '{32'h0000_100A, 1'b0, 4'd0},  // R1 compressed mode off
    '{32'h0000_4FFE, 1'b1, 4'd1},  // R6 second half faults, page crossing
    '{32'h0000_5002, 1'b1, 4'd0},  // R5 first half faults
    '{32'h0000_5004, 1'b1, 4'd0},  // R5 aligned fault
    '{32'h0000_3FFE, 1'b1, 4'd3},  // R3 page crossing, no fault
    '{32'h0000_2006, 1'b1, 4'd0},  // R4
    '{32'h0000_2008, 1'b1, 4'd0},  // R8 aligned, full length
    '{32'h0000_2000, 1'b1, 4'd0},  // R8 aligned, compressed
    '{32'h0000_2000, 1'b0, 4'd0}   // R8 mode off
  };

  // returns after result seen at a negedge
  task automatic waitResult(output bit got);
    got = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (insnValid || faultValid) begin got = 1; break; end
    end
  endtask

  task automatic checkResult(input exp_t e, input bit got);
    chk(got, {e.tag, " result appears"}, 64'(got), 64'd1);
    chk(faultValid == e.isFault && insnValid == !e.isFault, {e.tag, " result kind"},
        64'({insnValid, faultValid}), 64'({!e.isFault, e.isFault}));
    if (e.isFault)
      chk(faultAddr == e.fAddr, {e.tag, " fault address"}, 64'(faultAddr), 64'(e.fAddr));
    else begin
      chk(insnData == e.data, {e.tag, " instruction data"}, 64'(insnData), 64'(e.data));
      chk(insnCompressed == e.comp, {e.tag, " compressed flag"}, 64'(insnCompressed), 64'(e.comp));
    end
    chk(rdCount == e.nRd, {e.tag, " read count"}, 64'(rdCount), 64'(e.nRd));
    chk(rdAddr0 == e.firstAddr && rdWide0 == e.firstWide, {e.tag, " first read"},
        64'({rdWide0, rdAddr0}), 64'({e.firstWide, e.firstAddr}));
    if (e.nRd == 2)
      chk(rdAddr1 == e.firstAddr + 2, "R3 second read address", 64'(rdAddr1), 64'(e.firstAddr + 2));
    @(negedge clk);
    chk(!insnValid && !faultValid, "R7 result is one pulse", 64'({insnValid, faultValid}), 64'd0);
  endtask

  task automatic doFetch(input logic [AW-1:0] a, input bit en, input int l);
    exp_t e;
    bit got;
    e = refModel(a, en);
    @(negedge clk);
    lat = l; rdCount = 0;
    chk(reqReady, "R7 ready when idle", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqAddr = a; reqCompEn = en;
    @(negedge clk);
    reqValid = 1'b0;
    waitResult(got);
    checkResult(e, got);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : main
    exp_t e;
    bit got;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(reqReady == 1'b1, "R9 ready in reset", 64'(reqReady), 64'd1);
    chk(!memReqValid && !insnValid && !faultValid, "R9 outputs idle in reset",
        64'({memReqValid, insnValid, faultValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !memReqValid, "R9 idle after reset", 64'({reqReady, memReqValid}), 64'h2);

    for (int v = 0; v < NV; v++)
      doFetch(VECS[v].addr, VECS[v].en, int'(VECS[v].lat));

    // R7: request held high with another address while busy is ignored
    e = refModel(32'h0000_100A, 1'b1);
    @(negedge clk);
    lat = 2; rdCount = 0;
    reqValid = 1'b1; reqAddr = 32'h0000_100A; reqCompEn = 1'b1;
    @(negedge clk);
    reqAddr = 32'h0000_1000; reqCompEn = 1'b0;
    chk(!reqReady, "R7 not ready while busy", 64'(reqReady), 64'd0);
    got = 0;
    for (int i = 0; i < 60; i++) begin
      if (insnValid || faultValid) begin got = 1; break; end
      @(negedge clk);
    end
    reqValid = 1'b0;
    checkResult(e, got);
    chk(rdCount == 2, "R7 no extra fetch from busy request", 64'(rdCount), 64'd2);

    summary();
  end

endmodule